// File: doc/BRIEF.md
# Gated Moving-Average Baseline Tracker

This block estimates the pedestal of a stream of 16-bit signed ADC samples. The estimate is the mean of the most recent quiet samples. Each sample arrives with a valid strobe and a quiet qualifier. The qualifier comes from the downstream restoration stage and is high when the sample lies outside any pulse or discharge region.

The block keeps a running sum and a circular history buffer that holds one window of samples.

- **Start-up fill:** after reset, the first window of valid samples is loaded without regard to the qualifier. The ready flag rises when this fill is complete.
- **Tracking:** after the fill, only quiet samples change the window. Each quiet sample displaces the quiet sample that entered one full window of updates earlier. Samples taken during a pulse leave the window as it was.

The estimate is the running sum divided by the window length and truncated toward zero.

A second output carries a lagged copy of the estimate for the filter path. It advances by one step on every accepted sample. A sample presented on the input therefore pairs with the estimate as it stood two samples before it.

Top module: `bl_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `base_now` = 0, `base_lag` = 0 and `ready` = 0.
- R2: After reset, the first 1024 samples with `in_valid` = 1 all enter the window, whatever `in_idle` is. `ready` goes to 1 after the edge that accepts the 1024th sample, and it then stays 1 until reset.
- R3: `base_now` is the sum of the samples currently in the window divided by 1024, truncated toward zero. A sum of -5 gives 0, not -1. During the fill, the sum covers only the samples loaded so far.
- R4: Once `ready` = 1, a sample with `in_valid` = 1 and `in_idle` = 1 is added to the sum. The sample that entered 1024 such updates earlier is removed from it.
- R5: Once `ready` = 1, a sample with `in_valid` = 1 and `in_idle` = 0 leaves `base_now` unchanged. It also does not advance the window, so later quiet samples still displace the same oldest entries.
- R6: In a cycle with `in_valid` = 0, `base_now`, `base_lag` and `ready` keep their values.
- R7: After the edge that accepts a valid sample, `base_lag` equals the value `base_now` had just before that edge. `base_lag` advances on every valid sample, quiet or not.
- R8: The sum never overflows. A window full of -32768 gives `base_now` = -32768, and a window full of 32767 gives 32767.
- R9: A reset in the middle of a run clears the estimate, drops `ready`, and starts a new fill of 1024 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; 1 = `in_sample` is accepted this cycle |
| in_idle | input | 1 | Quiet qualifier; 1 = sample lies outside pulse and discharge regions |
| in_sample | input | 16 | Signed two's-complement ADC sample |
| base_now | output | 16 | Signed current estimate, truncated toward zero |
| base_lag | output | 16 | Signed estimate for the filter path, lagged one accepted sample behind `base_now` |
| ready | output | 1 | 1 once the start-up fill is complete |

## Verification
A corrupt history pointer or a stale buffer entry stays hidden until the window wraps. The wrong value only surfaces at the ports 1024 quiet updates later, as a baseline step. For this reason the bench runs several full windows with distinct contents and checks every accepted sample against an independent model.

A sign or rounding fault in the divide shows at once on small negative sums. A sum that is wrongly updated on pulse samples moves `base_now` on the very next edge.

// File: rtl/bl_pkg.sv
// Shared definitions for the baseline tracker.
// Assumes: consumers import the phase type; no parameters live here.
package bl_pkg;

    // Operating phase of the tracker: loading the first window, then gated tracking.
    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_TRACK = 1'b1
    } phase_e;

endpackage

// File: rtl/bl_history.sv
// Circular history buffer of window samples with a write pointer.
// The entry under the pointer is the oldest one and is presented combinationally,
// so the caller can subtract it in the same cycle the new sample overwrites it.
// Assumes: the storage needs no reset; the caller masks the old value while filling.
module bl_history #(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    output logic signed [DW-1:0] old_data,
    output logic                 at_last
);
    localparam int DEPTH = 1 << AW;

    logic signed [DW-1:0] mem [DEPTH];
    logic        [AW-1:0] ptr_q;

    // Pointer: advances on each write and wraps at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (wr_en) ptr_q <= ptr_q + 1'b1;
    end

    // Storage: overwrite the oldest entry with the incoming sample.
    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr_q] <= wr_data;
    end

    // Read port: expose the oldest entry and flag the final slot.
    always_comb begin
        old_data = mem[ptr_q];
        at_last  = (ptr_q == AW'(DEPTH - 1));
    end
endmodule

// File: rtl/bl_accum.sv
// Running-sum accumulator, fill/track phase control and divide-by-window.
// Assumes: sample widths are sign-extended by AW bits, so a full window of
// extreme values fits; the quotient rounds toward zero for negative sums.
module bl_accum
    import bl_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [DW-1:0] add_data,
    input  logic signed [DW-1:0] sub_data,
    input  logic                 wrap,
    output logic signed [DW-1:0] base,
    output logic                 tracking
);
    localparam int SW = DW + AW;

    phase_e               phase_q;
    logic signed [SW-1:0] sum_q;
    logic signed [SW-1:0] add_x;
    logic signed [SW-1:0] sub_x;
    logic                 round_up;

    // Operand prep: widen both samples; nothing leaves the window while filling.
    always_comb begin
        add_x = {{AW{add_data[DW-1]}}, add_data};
        if (phase_q == PH_TRACK) sub_x = {{AW{sub_data[DW-1]}}, sub_data};
        else                     sub_x = '0;
    end

    // Running sum: add the newcomer, drop the evicted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   sum_q <= '0;
        else if (upd) sum_q <= sum_q + add_x - sub_x;
    end

    // Phase: leave fill once the last slot of the first window is written.
    always_ff @(posedge clk) begin
        if (!rst_n)                              phase_q <= PH_FILL;
        else if (upd && wrap && phase_q == PH_FILL) phase_q <= PH_TRACK;
    end

    // Divide: arithmetic shift, then lift negative inexact quotients toward zero.
    always_comb begin
        round_up = sum_q[SW-1] && (|sum_q[AW-1:0]);
        base     = sum_q[SW-1:AW] + {{(DW-1){1'b0}}, round_up};
        tracking = (phase_q == PH_TRACK);
    end
endmodule

// File: rtl/bl_lag.sv
// Delay line carrying the estimate to the filter path.
// Captures the estimate as it stands before each accepted sample, so the
// output trails by LAG-1 accepted samples and the next input pairs with a
// value LAG samples old. Assumes LAG >= 2.
module bl_lag #(
    parameter int DW  = 16,
    parameter int LAG = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic signed [DW-1:0] d,
    output logic signed [DW-1:0] q
);
    localparam int STAGES = LAG - 1;

    logic signed [DW-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Stage g: shift one step per accepted sample.
        always_ff @(posedge clk) begin
            if (!rst_n)   stg_q[g] <= '0;
            else if (adv) stg_q[g] <= (g == 0) ? d : stg_q[(g == 0) ? 0 : g - 1];
        end
    end

    // Output tap: the last stage of the chain.
    always_comb q = stg_q[STAGES-1];
endmodule

// File: rtl/bl_tracker.sv
// Top of the gated moving-average baseline tracker.
// Fills one window unconditionally after reset, then folds in only quiet
// samples. Presents the current and the lagged estimate.
// Assumes: in_sample is two's complement; in_idle is meaningful only with in_valid.
module bl_tracker #(
    parameter int DW  = 16,
    parameter int AW  = 10,
    parameter int LAG = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_idle,
    input  logic signed [DW-1:0] in_sample,
    output logic signed [DW-1:0] base_now,
    output logic signed [DW-1:0] base_lag,
    output logic                 ready
);
    logic                 upd;
    logic                 wrap;
    logic signed [DW-1:0] old_smp;

    // Update gate: every valid sample while filling, only quiet ones afterwards.
    always_comb upd = in_valid && (!ready || in_idle);

    bl_history #(.DW(DW), .AW(AW)) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd),
        .wr_data  (in_sample),
        .old_data (old_smp),
        .at_last  (wrap)
    );

    bl_accum #(.DW(DW), .AW(AW)) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .add_data (in_sample),
        .sub_data (old_smp),
        .wrap     (wrap),
        .base     (base_now),
        .tracking (ready)
    );

    bl_lag #(.DW(DW), .LAG(LAG)) i_lag (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .d     (base_now),
        .q     (base_lag)
    );
endmodule

// File: rtl/bl_tracker_chk.sv
// Port-level property checker for bl_tracker, attached by bind.
module bl_tracker_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_idle,
    input logic signed [DW-1:0] base_now,
    input logic signed [DW-1:0] base_lag,
    input logic                 ready
);
    // R1: reset clears the visible state.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (base_now == '0 && base_lag == '0 && !ready));

    // R2: ready is sticky until reset.
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R5: busy samples after the fill leave the estimate untouched.
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_idle && ready) |=> $stable(base_now));

    // R6: no strobe, no change.
    p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(base_now) && $stable(base_lag) && $stable(ready)));

    // R7: the lagged output takes the pre-edge estimate on each accepted sample.
    p_lag_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (base_lag == $past(base_now)));
endmodule

bind bl_tracker bl_tracker_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_idle  (in_idle),
    .base_now (base_now),
    .base_lag (base_lag),
    .ready    (ready)
);

// File: tb/test_bl_tracker.sv
// Scoreboard bench: the driver models each sample and queues the expectation,
// the monitor compares outputs shortly after the accepting edge.
module test_bl_tracker;
    localparam int DW  = 16;
    localparam int AW  = 10;
    localparam int WIN = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_idle = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic signed [DW-1:0] base_now;
    logic signed [DW-1:0] base_lag;
    logic                 ready;

    always #4 clk = ~clk;

    bl_tracker #(.DW(DW), .AW(AW), .LAG(2)) i_bl_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idle(in_idle),
        .in_sample(in_sample), .base_now(base_now), .base_lag(base_lag), .ready(ready)
    );

    typedef struct { int b; int l; bit r; string tag; } exp_t;
    exp_t sb[$];

    int     n_chk = 0;
    int     n_bad = 0;
    int     m_hist [WIN];
    int     m_ptr;
    longint m_sum;
    bit     m_ready;
    int     m_base;
    int     m_lag;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_ptr = 0; m_sum = 0; m_ready = 0; m_base = 0; m_lag = 0;
    endtask

    // Driver: present one sample, update the model, queue the expectation.
    task automatic drive(int s, bit idle, string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_idle   = idle;
        in_sample = DW'(s);
        m_lag = m_base;
        if (!m_ready || idle) begin
            m_sum = m_sum + s - (m_ready ? m_hist[m_ptr] : 0);
            m_hist[m_ptr] = s;
            m_ptr = (m_ptr + 1) % WIN;
            if (!m_ready && m_ptr == 0) m_ready = 1;
        end
        m_base = int'(m_sum / WIN);
        e.b = m_base; e.l = m_lag; e.r = m_ready; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic gap(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_idle  = 1'b0;
            in_sample = DW'(16'h7abc);
        end
    endtask

    task automatic do_reset(string tag);
        gap(1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        check({tag, " base_now"}, int'(base_now), 0);
        check({tag, " base_lag"}, int'(base_lag), 0);
        check({tag, " ready"}, int'(ready), 0);
    endtask

    // Monitor: after each accepting edge, pop and compare.
    always @(posedge clk) begin
        if (in_valid && rst_n) begin
            exp_t e;
            #2;
            e = sb.pop_front();
            check({e.tag, " base_now"}, int'(base_now), e.b);
            check("R7 base_lag", int'(base_lag), e.l);
            check("R2 ready", int'(ready), int'(e.r));
        end
    end

    task automatic finish_all();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_all();
    end

    initial begin
        model_clear();
        do_reset("R1");
        // R2: fill ignores the qualifier; R3 ramps the partial sum.
        for (int i = 0; i < WIN; i++) drive(100 + (i % 7) * 3, (i % 3) != 0, "R2");
        gap(1);
        check("R2 ready after fill", int'(ready), 1);
        // R4 quiet updates interleaved with R5 pulse samples.
        for (int i = 0; i < 400; i++) begin
            if (i % 10 == 9) drive(5000, 1'b0, "R5");
            else             drive(200 + (i % 5), 1'b1, "R4");
        end
        // R6: strobe low, outputs hold.
        gap(6);
        check("R6 base_now hold", int'(base_now), m_base);
        check("R6 base_lag hold", int'(base_lag), m_lag);
        // R3: small negative sum truncates toward zero.
        for (int i = 0; i < WIN; i++) drive(0, 1'b1, "R3");
        drive(-5, 1'b1, "R3");
        drive(-3000, 1'b0, "R5");
        for (int i = 0; i < 20; i++) drive(-7, 1'b1, "R3");
        // R8: full-scale windows in both directions.
        for (int i = 0; i < WIN; i++) drive(-32768, 1'b1, "R8");
        gap(1);
        check("R8 negative full scale", int'(base_now), -32768);
        for (int i = 0; i < WIN; i++) drive(32767, 1'b1, "R8");
        gap(1);
        check("R8 positive full scale", int'(base_now), 32767);
        // R9: reset mid-run restarts the fill.
        do_reset("R9");
        for (int i = 0; i < 10; i++) drive(-50 * i, i % 2 == 0, "R9");
        gap(1);
        check("R9 ready low in refill", int'(ready), 0);
        gap(2);
        finish_all();
    end
endmodule